// File: doc/BRIEF.md
# Edge-Coincidence Lock Detector with Hysteresis

This block decides whether a phase-locked loop is locked by watching the rising edges of the two signals that feed its phase detector: the divided reference and the divided feedback. Both arrive already synchronous to a fast sample clock. Time is measured in cycles of that clock. For each pair of edges, the block counts the cycles from the first edge to its partner.

A lock flag is raised after several consecutive pairs land inside a narrow set window. Once raised, the flag falls only when a pair is separated by at least a wider clear threshold. A pair whose partner never arrives also counts as separated. A separation between the two limits leaves the flag as it is, which gives hysteresis.

A select input chooses between two window pairs. A disable input holds the detector unlocked. A polarity input picks whether the status output is high or low when locked. Loss of the reference is not detected here: if both inputs stop, the flag may stay set.

Top module: `lock_detect_top`

## Requirements
- R1: A rising edge is a sample at 1 whose previous sample was 0. The separation of a pair is the number of sample-clock cycles from the first edge to the partner edge on the other input. Edges on both inputs in the same cycle form a pair with separation 0.
- R2: While unlocked, the flag rises when SET_PAIRS (default 3) consecutive pairs have a separation no greater than the set window. With windowSel=0 the set window is SET_WIN0 = 19 cycles.
- R3: While unlocked, a completed pair whose separation exceeds the set window restarts the count of consecutive coincident pairs. With windowSel=0, a separation of 19 counts and 20 does not.
- R4: While locked, a pair with separation at or above the clear threshold drops the flag. A separation below it leaves the flag set. With windowSel=0 the clear threshold is CLR_WIN0 = 30, so 29 holds and 30 clears.
- R5: With windowSel=1 the set window is SET_WIN1 = 7 and the clear threshold is CLR_WIN1 = 14.
- R6: If CLR_WIN cycles pass after a first edge with no partner edge, the pair counts as separated and the flag drops.
- R7: Either input may lead a pair, and the result is the same.
- R8: While detectOff=1 the flag is held unlocked and the pair state and count are cleared. When detectOff returns to 0, a full run of SET_PAIRS coincident pairs is needed again. A disable in the same cycle as a completing pair wins.
- R9: lockOut equals the flag when activeLow=0 and its inverse when activeLow=1.
- R10: A synchronous reset clears the flag, the pair state and the count.
- R11: A second rising edge on the leading input before its partner arrives counts as a separated pair and starts a new pair from that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| refIn | input | 1 | Divided reference, synchronous to clk |
| fbIn | input | 1 | Divided feedback, synchronous to clk |
| windowSel | input | 1 | 0 selects window pair 0, 1 selects window pair 1 |
| detectOff | input | 1 | 1 holds the detector unlocked |
| activeLow | input | 1 | 1 inverts lockOut |
| lockOut | output | 1 | Lock status at the chosen polarity |

## Verification
Two events can land in the same cycle. One is the partner edge arriving in exactly the cycle the clear-threshold timeout expires. The other is a disable arriving together with the pair that would complete a lock run. The bench places the partner edge at exactly 30 cycles in mode 0, and it raises detectOff on the same sample as the third coincident partner edge. In the first case the flag must fall. In the second case it must stay unlocked, and a fresh run of three coincident pairs must then be needed to lock.

// File: rtl/lock_detect_pkg.sv
package lock_detect_pkg;

  typedef enum logic [1:0] {
    PAIR_IDLE    = 2'd0,
    PAIR_WAITFB  = 2'd1,
    PAIR_WAITREF = 2'd2
  } pairState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic cntLoad;  // first edge seen: counter becomes 1
    logic cntInc;   // still waiting: advance counter
    logic cntClr;   // pair finished or abandoned
  } cntStrobe_t;

endpackage

// File: rtl/lock_detect_datapath.sv
module lock_detect_datapath
  import lock_detect_pkg::*;
#(
  parameter int SET_WIN0 = 19,
  parameter int CLR_WIN0 = 30,
  parameter int SET_WIN1 = 7,
  parameter int CLR_WIN1 = 14,
  parameter int CNT_W    = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       refIn,
  input  logic       fbIn,
  input  logic       windowSel,
  input  cntStrobe_t strobe,
  output logic       refEdge,
  output logic       fbEdge,
  output logic       sepInSet,
  output logic       sepAtClear,
  output logic       cntNonZero
);

  localparam int CLR_MAX = (CLR_WIN0 > CLR_WIN1) ? CLR_WIN0 : CLR_WIN1;

  logic             refPrev;
  logic             fbPrev;
  logic [CNT_W-1:0] sepCnt;
  logic [CNT_W-1:0] setLimit;
  logic [CNT_W-1:0] clrLimit;

  always_ff @(posedge clk) begin
    if (rst) begin
      refPrev <= 1'b0;
      fbPrev  <= 1'b0;
    end else begin
      refPrev <= refIn;
      fbPrev  <= fbIn;
    end
  end

  assign refEdge = refIn & ~refPrev;
  assign fbEdge  = fbIn & ~fbPrev;

  always_ff @(posedge clk) begin
    if (rst || strobe.cntClr) begin
      sepCnt <= '0;
    end else if (strobe.cntLoad) begin
      sepCnt <= CNT_W'(1);
    end else if (strobe.cntInc) begin
      sepCnt <= sepCnt + CNT_W'(1);
    end
  end

  always_comb begin
    if (windowSel) begin
      setLimit = CNT_W'(SET_WIN1);
      clrLimit = CNT_W'(CLR_WIN1);
    end else begin
      setLimit = CNT_W'(SET_WIN0);
      clrLimit = CNT_W'(CLR_WIN0);
    end
  end

  assign sepInSet   = (sepCnt <= setLimit);
  assign sepAtClear = (sepCnt >= clrLimit);
  assign cntNonZero = (sepCnt != '0);

  // R6: the separation count never runs past the widest clear threshold
  a_r6_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    sepCnt <= CNT_W'(CLR_MAX));

endmodule

// File: rtl/lock_detect_control.sv
module lock_detect_control
  import lock_detect_pkg::*;
#(
  parameter int SET_PAIRS = 3,
  parameter int RUN_W     = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       detectOff,
  input  logic       refEdge,
  input  logic       fbEdge,
  input  logic       sepInSet,
  input  logic       sepAtClear,
  input  logic       cntNonZero,
  output cntStrobe_t strobe,
  output logic       lockFlag
);

  pairState_t       pairState;
  pairState_t       pairNext;
  logic [RUN_W-1:0] runCnt;
  logic             pairGood;   // completed pair inside set window
  logic             pairBad;    // separated pair or timeout
  logic             pairMid;    // completed pair between the limits
  logic             partnerEdge;
  logic             leaderEdge;

  always_comb begin
    partnerEdge = 1'b0;
    leaderEdge  = 1'b0;
    case (pairState)
      PAIR_WAITFB: begin
        partnerEdge = fbEdge;
        leaderEdge  = refEdge;
      end
      PAIR_WAITREF: begin
        partnerEdge = refEdge;
        leaderEdge  = fbEdge;
      end
      default: ;
    endcase
  end

  always_comb begin
    pairNext = pairState;
    strobe   = '0;
    pairGood = 1'b0;
    pairBad  = 1'b0;
    pairMid  = 1'b0;
    if (pairState == PAIR_IDLE) begin
      if (refEdge && fbEdge) begin
        pairGood = 1'b1;
      end else if (refEdge) begin
        pairNext       = PAIR_WAITFB;
        strobe.cntLoad = 1'b1;
      end else if (fbEdge) begin
        pairNext       = PAIR_WAITREF;
        strobe.cntLoad = 1'b1;
      end
    end else begin
      if (partnerEdge) begin
        pairNext      = PAIR_IDLE;
        strobe.cntClr = 1'b1;
        if (sepAtClear) begin
          pairBad = 1'b1;
        end else if (sepInSet) begin
          pairGood = 1'b1;
        end else begin
          pairMid = 1'b1;
        end
      end else if (leaderEdge) begin
        pairBad        = 1'b1;
        strobe.cntLoad = 1'b1;
      end else if (sepAtClear) begin
        pairBad       = 1'b1;
        pairNext      = PAIR_IDLE;
        strobe.cntClr = 1'b1;
      end else begin
        strobe.cntInc = 1'b1;
      end
    end
    if (detectOff) begin
      pairNext = PAIR_IDLE;
      strobe   = '0;
      strobe.cntClr = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pairState <= PAIR_IDLE;
    end else begin
      pairState <= pairNext;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || detectOff) begin
      lockFlag <= 1'b0;
      runCnt   <= '0;
    end else if (pairBad) begin
      lockFlag <= 1'b0;
      runCnt   <= '0;
    end else if (pairGood && !lockFlag) begin
      if (runCnt == RUN_W'(SET_PAIRS - 1)) begin
        lockFlag <= 1'b1;
        runCnt   <= '0;
      end else begin
        runCnt <= runCnt + RUN_W'(1);
      end
    end else if (pairMid && !lockFlag) begin
      runCnt <= '0;
    end
  end

  // R8: a disable leaves the flag low on the next cycle
  a_r8_off_forces_unlock: assert property (@(posedge clk) disable iff (rst)
    detectOff |=> !lockFlag);

  // R2: the flag only rises right after a coincident edge arrival
  a_r2_rise_needs_edge: assert property (@(posedge clk) disable iff (rst)
    $rose(lockFlag) |-> $past((refEdge || fbEdge) && sepInSet && !detectOff));

  // R4: the flag only falls on disable, an edge or a threshold hit
  a_r4_fall_has_cause: assert property (@(posedge clk) disable iff (rst)
    $fell(lockFlag) |-> $past(detectOff || refEdge || fbEdge || sepAtClear));

  // R1: while a pair is open the datapath counter is running
  a_r1_open_pair_counts: assert property (@(posedge clk) disable iff (rst)
    (pairState != PAIR_IDLE) |-> cntNonZero);

endmodule

// File: rtl/lock_detect_top.sv
module lock_detect_top
  import lock_detect_pkg::*;
#(
  parameter int SET_WIN0  = 19,
  parameter int CLR_WIN0  = 30,
  parameter int SET_WIN1  = 7,
  parameter int CLR_WIN1  = 14,
  parameter int SET_PAIRS = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic refIn,
  input  logic fbIn,
  input  logic windowSel,
  input  logic detectOff,
  input  logic activeLow,
  output logic lockOut
);

  localparam int CLR_MAX = (CLR_WIN0 > CLR_WIN1) ? CLR_WIN0 : CLR_WIN1;
  localparam int CNT_W   = $clog2(CLR_MAX + 1);
  localparam int RUN_W   = (SET_PAIRS > 1) ? $clog2(SET_PAIRS) : 1;

  cntStrobe_t strobe;
  logic refEdge, fbEdge, sepInSet, sepAtClear, cntNonZero, lockFlag;

  lock_detect_datapath #(
    .SET_WIN0(SET_WIN0), .CLR_WIN0(CLR_WIN0),
    .SET_WIN1(SET_WIN1), .CLR_WIN1(CLR_WIN1),
    .CNT_W(CNT_W)
  ) u_datapath (
    .clk(clk), .rst(rst), .refIn(refIn), .fbIn(fbIn),
    .windowSel(windowSel), .strobe(strobe),
    .refEdge(refEdge), .fbEdge(fbEdge),
    .sepInSet(sepInSet), .sepAtClear(sepAtClear),
    .cntNonZero(cntNonZero)
  );

  lock_detect_control #(
    .SET_PAIRS(SET_PAIRS), .RUN_W(RUN_W)
  ) u_control (
    .clk(clk), .rst(rst), .detectOff(detectOff),
    .refEdge(refEdge), .fbEdge(fbEdge),
    .sepInSet(sepInSet), .sepAtClear(sepAtClear),
    .cntNonZero(cntNonZero), .strobe(strobe), .lockFlag(lockFlag)
  );

  assign lockOut = activeLow ? ~lockFlag : lockFlag;

endmodule

// File: tb/lock_detect_top_tb.sv
module lock_detect_top_tb;

  logic clk = 1'b0;
  logic rst, refIn, fbIn, windowSel, detectOff, activeLow;
  logic lockOut;
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 1'b0;

  always #4 clk = ~clk;

  lock_detect_top u_dut (
    .clk(clk), .rst(rst), .refIn(refIn), .fbIn(fbIn),
    .windowSel(windowSel), .detectOff(detectOff),
    .activeLow(activeLow), .lockOut(lockOut)
  );

  task automatic check(input logic exp, input string tag);
    checks++;
    if (lockOut !== exp) begin
      fails++;
      $display("FAIL %s: lockOut=%b expected=%b", tag, lockOut, exp);
    end
  endtask

  task automatic doReset(input logic sel, input logic pol);
    @(negedge clk);
    rst = 1'b1; refIn = 1'b0; fbIn = 1'b0;
    detectOff = 1'b0; windowSel = sel; activeLow = pol;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  // lead edge, then partner edge sep cycles later; both dropped after
  task automatic pair(input int sep, input bit fbFirst);
    @(negedge clk);
    if (sep == 0) begin
      refIn = 1'b1; fbIn = 1'b1;
    end else begin
      if (fbFirst) fbIn = 1'b1; else refIn = 1'b1;
      repeat (sep) @(negedge clk);
      if (fbFirst) refIn = 1'b1; else fbIn = 1'b1;
    end
    @(negedge clk);
    refIn = 1'b0; fbIn = 1'b0;
    @(negedge clk);
  endtask

  task automatic lockUp(input int sep);
    for (int i = 0; i < 3; i++) pair(sep, 1'b0);
  endtask

  task automatic t_reset();
    doReset(1'b0, 1'b0);
    check(1'b0, "R10 reset unlocked");
  endtask

  task automatic t_setRun();
    doReset(1'b0, 1'b0);
    pair(5, 1'b0); pair(0, 1'b0);
    check(1'b0, "R2 two pairs not enough");
    pair(19, 1'b0);
    check(1'b1, "R2 third coincident pair locks");
    pair(0, 1'b0);
    check(1'b1, "R1 zero-separation pair keeps lock");
  endtask

  task automatic t_setBoundary();
    doReset(1'b0, 1'b0);
    pair(19, 1'b0); pair(19, 1'b0); pair(20, 1'b0);
    check(1'b0, "R3 sep 20 breaks run");
    pair(19, 1'b0); pair(19, 1'b0);
    check(1'b0, "R3 run restarted");
    pair(19, 1'b0);
    check(1'b1, "R3 fresh run locks");
  endtask

  task automatic t_hyst();
    doReset(1'b0, 1'b0);
    lockUp(3);
    pair(29, 1'b0);
    check(1'b1, "R4 sep 29 holds");
    pair(25, 1'b0);
    check(1'b1, "R4 sep 25 holds");
    pair(30, 1'b0);
    check(1'b0, "R4 R6 partner at threshold clears");
  endtask

  task automatic t_mode1();
    doReset(1'b1, 1'b0);
    pair(7, 1'b0); pair(7, 1'b0); pair(8, 1'b0);
    check(1'b0, "R5 sep 8 outside set window");
    lockUp(7);
    check(1'b1, "R5 sep 7 locks");
    pair(13, 1'b0);
    check(1'b1, "R5 sep 13 holds");
    pair(14, 1'b0);
    check(1'b0, "R5 sep 14 clears");
  endtask

  task automatic t_fbFirst();
    doReset(1'b0, 1'b0);
    for (int i = 0; i < 3; i++) pair(10, 1'b1);
    check(1'b1, "R7 feedback-first locks");
    pair(30, 1'b1);
    check(1'b0, "R7 feedback-first separation clears");
  endtask

  task automatic t_timeout();
    doReset(1'b0, 1'b0);
    lockUp(2);
    @(negedge clk);
    refIn = 1'b1;
    repeat (30) @(negedge clk);
    check(1'b1, "R6 still locked before timeout");
    @(negedge clk);
    check(1'b0, "R6 timeout clears");
    refIn = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_repeat();
    doReset(1'b0, 1'b0);
    lockUp(2);
    @(negedge clk); refIn = 1'b1;
    @(negedge clk); refIn = 1'b0;
    @(negedge clk); refIn = 1'b1;
    @(negedge clk);
    check(1'b0, "R11 repeated leading edge clears");
    refIn = 1'b0;
    repeat (40) @(negedge clk);
  endtask

  task automatic t_disable();
    doReset(1'b0, 1'b0);
    lockUp(4);
    @(negedge clk); detectOff = 1'b1;
    @(negedge clk);
    check(1'b0, "R8 disable clears lock");
    lockUp(4);
    check(1'b0, "R8 pairs ignored while off");
    detectOff = 1'b0;
    pair(4, 1'b0); pair(4, 1'b0);
    check(1'b0, "R8 full run needed after enable");
    pair(4, 1'b0);
    check(1'b1, "R8 relock after enable");
    // disable lands on the third coincident partner edge
    doReset(1'b0, 1'b0);
    pair(4, 1'b0); pair(4, 1'b0);
    @(negedge clk); refIn = 1'b1;
    repeat (4) @(negedge clk);
    fbIn = 1'b1; detectOff = 1'b1;
    @(negedge clk);
    check(1'b0, "R8 disable wins over completing pair");
    refIn = 1'b0; fbIn = 1'b0; detectOff = 1'b0;
    @(negedge clk);
    pair(4, 1'b0); pair(4, 1'b0);
    check(1'b0, "R8 count cleared by coincident disable");
    pair(4, 1'b0);
    check(1'b1, "R8 relock after coincident disable");
  endtask

  task automatic t_polarity();
    doReset(1'b0, 1'b1);
    check(1'b1, "R9 active-low idle high");
    lockUp(6);
    check(1'b0, "R9 active-low locked low");
    @(negedge clk); detectOff = 1'b1;
    @(negedge clk);
    check(1'b1, "R9 active-low disabled high");
    detectOff = 1'b0;
  endtask

  initial begin
    rst = 1'b1; refIn = 1'b0; fbIn = 1'b0;
    windowSel = 1'b0; detectOff = 1'b0; activeLow = 1'b0;
    t_reset();
    t_setRun();
    t_setBoundary();
    t_hyst();
    t_mode1();
    t_fbFirst();
    t_timeout();
    t_repeat();
    t_disable();
    t_polarity();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule